// File: doc/BRIEF.md
# Four-Mode Barrel Shift Unit

This block is the shift execution unit of a 32-bit processor datapath. It takes the current instruction word together with two register operands: the value to be shifted, and a second register whose low bits can supply the shift count. It produces the shifted value, the index of the destination register and a write enable for the register file. It handles four shift kinds: logical right, arithmetic right, logical left and circular left. Each kind is chosen by its own opcode.

A single opcode covers both the immediate form and the register-count form. The unit reads the 5-bit count in the low bits of the instruction's 12-bit modifier field. When that count is nonzero it is used as the shift amount. When it is zero, the low 5 bits of the count register set the shift amount instead.

The shifter is a logarithmic chain of multiplexer stages. A parameter adds a result register after the chain, which makes the unit one clock stage deep instead of purely combinational.

Top module: `bsh_unit`

## Requirements
- R1: Opcode field instr[31:27] selects the operation: 26 is logical right, 27 arithmetic right, 28 logical left, 29 circular left. No other opcode is treated as a shift.
- R2: The shift amount n is instr[4:0] when that value is nonzero. Otherwise n is in_count_reg[4:0]. Modifier bits instr[11:5] and count register bits above 4 never change the result.
- R3: For logical right, result bits 31-n..0 equal operand bits 31..n, and the top n bits are zero.
- R4: For arithmetic right, the top n result bits are copies of operand bit 31, and the bits below them equal operand bits 31..n. For example, shifting 0x97EAEC16 right by 13 gives 0xFFFCBF57.
- R5: For logical left, result bits 31..n equal operand bits 31-n..0, and the low n bits are zero.
- R6: Circular left moves the top n operand bits into the bottom n result positions. The ones count of the result therefore equals that of the operand.
- R7: When the count is taken from the register and is zero, the result equals the operand in all four modes.
- R8: out_we is high only when in_valid is high and the opcode is 26 to 29.
- R9: When out_we is high, out_dst equals instr[26:22] of the same instruction.
- R10: When out_we is low, out_result is zero.
- R11: With REG_OUT=1, the outputs appear one clock after their inputs. During reset, out_we and out_result are zero. With REG_OUT=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 32 | Instruction word: opcode, destination field and modifier field |
| in_operand | input | W | Value to shift (the rb operand) |
| in_count_reg | input | W | Register count source (the rc operand) |
| out_result | output | W | Shifted value |
| out_dst | output | 5 | Destination register index |
| out_we | output | 1 | Register write enable |

## Verification
The bench builds two copies side by side from the same stimulus. One uses REG_OUT=1 and is checked one clock after each input. The other uses REG_OUT=0 and is checked in the same cycle. This puts both the registered and the purely combinational output paths within reach, along with the reset state of the register.

Random vectors cover all shift counts from both count sources, plus random non-shift opcodes and dropped strobes. Directed vectors cover these cases:
- the arithmetic-right worked value;
- a zero count taken from the register;
- the maximum count of 31;
- modifier bits above 4 set, which must have no effect.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
    localparam int INSTR_W  = 32;
    localparam int OPC_LSB  = 27;
    localparam int DST_LSB  = 22;
    localparam int FIELD_W  = 5;

    typedef enum logic [4:0] {
        OPC_SRL = 5'd26,
        OPC_SRA = 5'd27,
        OPC_SLL = 5'd28,
        OPC_ROL = 5'd29
    } bsh_opc_e;

    typedef enum logic [1:0] {
        MODE_SRL = 2'd0,
        MODE_SRA = 2'd1,
        MODE_SLL = 2'd2,
        MODE_ROL = 2'd3
    } bsh_mode_e;
endpackage

// File: rtl/bsh_decode.sv
module bsh_decode
    import bsh_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               valid,
    output logic               is_shift,
    output bsh_mode_e          mode,
    output logic [FIELD_W-1:0] dst,
    output logic [CW-1:0]      imm_cnt
);
    logic [FIELD_W-1:0] opc;
    logic [FIELD_W-1:0] rel;

    assign opc      = instr[OPC_LSB +: FIELD_W];
    assign dst      = instr[DST_LSB +: FIELD_W];
    assign imm_cnt  = instr[CW-1:0];
    assign rel      = opc - FIELD_W'(OPC_SRL);
    assign mode     = bsh_mode_e'(rel[1:0]);
    assign is_shift = valid && (opc == OPC_SRL || opc == OPC_SRA ||
                                opc == OPC_SLL || opc == OPC_ROL);
endmodule

// File: rtl/bsh_count_sel.sv
module bsh_count_sel #(
    parameter int CW = 5
) (
    input  logic [CW-1:0] imm_cnt,
    input  logic [CW-1:0] reg_cnt,
    output logic [CW-1:0] amount
);
    assign amount = (imm_cnt != '0) ? imm_cnt : reg_cnt;
endmodule

// File: rtl/bsh_core.sv
module bsh_core
    import bsh_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic [CW-1:0] amount,
    input  bsh_mode_e     mode,
    output logic [W-1:0]  result
);
    logic [CW:0][W-1:0] stg;

    assign stg[0] = operand;

    for (genvar k = 0; k < CW; k++) begin : g_stage
        localparam int SH = 1 << k;
        logic [W-1:0] srl_v, sra_v, sll_v, rol_v;
        assign srl_v = {{SH{1'b0}}, stg[k][W-1:SH]};
        assign sra_v = {{SH{stg[k][W-1]}}, stg[k][W-1:SH]};
        assign sll_v = {stg[k][W-1-SH:0], {SH{1'b0}}};
        assign rol_v = {stg[k][W-1-SH:0], stg[k][W-1:W-SH]};
        assign stg[k+1] = !amount[k]          ? stg[k] :
                          (mode == MODE_SRL) ? srl_v  :
                          (mode == MODE_SRA) ? sra_v  :
                          (mode == MODE_SLL) ? sll_v  : rol_v;
    end

    assign result = stg[CW];
endmodule

// File: rtl/bsh_unit.sv
module bsh_unit
    import bsh_pkg::*;
#(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [INSTR_W-1:0]    in_instr,
    input  logic [W-1:0]          in_operand,
    input  logic [W-1:0]          in_count_reg,
    output logic [W-1:0]          out_result,
    output logic [FIELD_W-1:0]    out_dst,
    output logic                  out_we
);
    localparam int CW = $clog2(W);

    logic               is_shift;
    bsh_mode_e          mode;
    logic [FIELD_W-1:0] dst;
    logic [CW-1:0]      imm_cnt;
    logic [CW-1:0]      amount;
    logic [W-1:0]       shifted;
    logic [W-1:0]       nxt_result;

    bsh_decode #(.CW(CW)) u_dec (
        .instr(in_instr), .valid(in_valid), .is_shift(is_shift),
        .mode(mode), .dst(dst), .imm_cnt(imm_cnt)
    );

    bsh_count_sel #(.CW(CW)) u_cnt (
        .imm_cnt(imm_cnt), .reg_cnt(in_count_reg[CW-1:0]), .amount(amount)
    );

    bsh_core #(.W(W), .CW(CW)) u_core (
        .operand(in_operand), .amount(amount), .mode(mode), .result(shifted)
    );

    assign nxt_result = is_shift ? shifted : '0;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_result <= '0;
                out_dst    <= '0;
                out_we     <= 1'b0;
            end else begin
                out_result <= nxt_result;
                out_dst    <= dst;
                out_we     <= is_shift;
            end
        end
    end else begin : g_comb
        assign out_result = nxt_result;
        assign out_dst    = dst;
        assign out_we     = is_shift;
    end
endmodule

// File: rtl/bsh_unit_chk.sv
module bsh_unit_chk #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [31:0]  in_instr,
    input logic [W-1:0] in_operand,
    input logic [W-1:0] in_count_reg,
    input logic [W-1:0] out_result,
    input logic [4:0]   out_dst,
    input logic         out_we
);
    logic         q_valid;
    logic [31:0]  q_instr;
    logic [W-1:0] q_opnd;
    logic [W-1:0] q_creg;

    if (REG_OUT) begin : g_lag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_valid <= 1'b0;
                q_instr <= '0;
                q_opnd  <= '0;
                q_creg  <= '0;
            end else begin
                q_valid <= in_valid;
                q_instr <= in_instr;
                q_opnd  <= in_operand;
                q_creg  <= in_count_reg;
            end
        end
    end else begin : g_now
        assign q_valid = in_valid;
        assign q_instr = in_instr;
        assign q_opnd  = in_operand;
        assign q_creg  = in_count_reg;
    end

    logic q_shift_op;
    assign q_shift_op = q_instr[31:27] >= 5'd26 && q_instr[31:27] <= 5'd29;

    AST_WE_ON_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_shift_op) |-> out_we);                          // R8
    AST_WE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_valid && q_shift_op) |-> !out_we);                        // R8
    AST_DST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> out_dst == q_instr[26:22]);                        // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_we |-> out_result == '0);                                // R10
    AST_ZERO_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && q_instr[4:0] == 5'd0 && q_creg[4:0] == 5'd0)
            |-> out_result == q_opnd);                                // R7
    AST_ROTATE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && q_instr[31:27] == 5'd29)
            |-> $countones(out_result) == $countones(q_opnd));        // R6
    AST_SRL_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && q_instr[31:27] == 5'd26 && q_instr[4:0] != 5'd0)
            |-> !out_result[W-1]);                                    // R3
    AST_SRA_TOP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && q_instr[31:27] == 5'd27)
            |-> out_result[W-1] == q_opnd[W-1]);                      // R4
endmodule

bind bsh_unit bsh_unit_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_operand(in_operand), .in_count_reg(in_count_reg),
    .out_result(out_result), .out_dst(out_dst), .out_we(out_we)
);

// File: tb/sim_bsh_unit.sv
module sim_bsh_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_operand = '0;
    logic [31:0] in_count_reg = '0;
    logic [31:0] r_res, c_res;
    logic [4:0]  r_dst, c_dst;
    logic        r_we, c_we;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bsh_unit #(.W(32), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_operand(in_operand), .in_count_reg(in_count_reg),
        .out_result(r_res), .out_dst(r_dst), .out_we(r_we));

    bsh_unit #(.W(32), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_operand(in_operand), .in_count_reg(in_count_reg),
        .out_result(c_res), .out_dst(c_dst), .out_we(c_we));

    function automatic logic [31:0] ref_shift(input logic [4:0] op,
            input logic [11:0] modf, input logic [31:0] a, input logic [31:0] c);
        int n;
        logic [31:0] r;
        n = (modf[4:0] != 0) ? int'(modf[4:0]) : int'(c[4:0]);
        for (int i = 0; i < 32; i++) begin
            case (op)
                5'd26: r[i] = (i + n < 32) ? a[i+n] : 1'b0;
                5'd27: r[i] = (i + n < 32) ? a[i+n] : a[31];
                5'd28: r[i] = (i >= n) ? a[i-n] : 1'b0;
                default: r[i] = a[(i - n + 32) % 32];
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [4:0] op, input logic [11:0] modf,
                                     input logic [31:0] c);
        string t;
        case (op)
            5'd26: t = "R3";
            5'd27: t = "R4";
            5'd28: t = "R5";
            default: t = "R6";
        endcase
        if (modf[4:0] == 0) t = {t, (c[4:0] == 0) ? " R7 R2" : " R2"};
        return {t, " R1"};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_out(input string who, input logic [31:0] res,
            input logic [4:0] dst, input logic we, input logic v,
            input logic [31:0] ins, input logic [31:0] a, input logic [31:0] c);
        logic [4:0] op;
        logic ew;
        op = ins[31:27];
        ew = v && op >= 5'd26 && op <= 5'd29;
        chk({who, " R8 we"}, {31'b0, we}, {31'b0, ew});
        if (ew) begin
            chk({who, " ", tag_of(op, ins[11:0], c)}, res, ref_shift(op, ins[11:0], a, c));
            chk({who, " R9 dst"}, {27'b0, dst}, {27'b0, ins[26:22]});
        end else begin
            chk({who, " R10 idle result"}, res, 32'h0);
        end
    endtask

    task automatic apply(input logic v, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] c);
        @(negedge clk);
        in_valid = v; in_instr = ins; in_operand = a; in_count_reg = c;
        #1;
        check_out("comb R11", c_res, c_dst, c_we, v, ins, a, c);
        @(posedge clk);
        #1;
        check_out("reg R11", r_res, r_dst, r_we, v, ins, a, c);
    endtask

    function automatic logic [31:0] mk(input logic [4:0] op, input logic [4:0] ra,
                                       input logic [11:0] modf);
        return {op, ra, 10'h0, modf};
    endfunction

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset we", {31'b0, r_we}, 32'h0);
        chk("R11 reset result", r_res, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 worked value
        apply(1'b1, mk(5'd27, 5'd1, 12'd13), 32'h97EAEC16, 32'h0);
        chk("R4 worked value", r_res, 32'hFFFCBF57);
        // R7 zero count from register, every mode
        for (int m = 26; m <= 29; m++)
            apply(1'b1, mk(5'(m), 5'd9, 12'h000), 32'hC3A5_0F1E, 32'hFFFF_FFE0);
        // R2 upper modifier bits ignored; count from register
        apply(1'b1, mk(5'd28, 5'd3, 12'hFE0), 32'h1234_5678, 32'h0000_0044);
        chk("R2 upper modifier ignored", r_res, 32'h2345_6780);
        // R2 immediate wins over register count
        apply(1'b1, mk(5'd26, 5'd4, 12'h008), 32'h8000_0001, 32'h0000_0003);
        chk("R3 R2 immediate count", r_res, 32'h0080_0000);
        // maximum counts
        apply(1'b1, mk(5'd29, 5'd5, 12'h01F), 32'h8000_0001, 32'h0);
        chk("R6 rotate 31", r_res, 32'hC000_0000);
        apply(1'b1, mk(5'd27, 5'd6, 12'h01F), 32'h8000_0000, 32'h0);
        chk("R4 sra 31", r_res, 32'hFFFF_FFFF);
        // R8 dropped strobe and R1 neighbouring opcodes
        apply(1'b0, mk(5'd26, 5'd7, 12'h001), 32'hFFFF_FFFF, 32'h0);
        apply(1'b1, mk(5'd25, 5'd7, 12'h001), 32'hFFFF_FFFF, 32'h0);
        apply(1'b1, mk(5'd30, 5'd7, 12'h001), 32'hFFFF_FFFF, 32'h0);

        for (int i = 0; i < 400; i++) begin
            logic [4:0]  op;
            logic [11:0] modf;
            op = ($urandom_range(0, 7) == 0) ? 5'($urandom_range(0, 31))
                                            : 5'($urandom_range(26, 29));
            modf = 12'($urandom);
            if ($urandom_range(0, 2) == 0) modf[4:0] = 5'd0;
            apply($urandom_range(0, 9) != 0, mk(op, 5'($urandom), modf),
                  $urandom, $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule